// File: doc/BRIEF.md
# Auto-Incrementing Serial Register Writer

This block is the write-only slave end of a three-wire control port. A host pulls chip-select low, clocks in a read/write flag and a seven-bit start address, and then streams any number of data bytes. Each byte that arrives in full lands in the register the internal address pointer names, and the pointer then moves on by one. It wraps from the top of the 80-entry bank back to zero. Two addresses are protected: bytes aimed at them are thrown away, but the pointer still steps past them.

The three port pins are sampled by a system clock that must run at least four times faster than the serial clock. Each pin passes through a two-flop synchronizer, and the serial clock's rising edge is found by edge detection. An active-low power-down input clears the whole bank at once, without waiting for a clock. A combinational read port shows the contents of the bank. A one-cycle strobe reports every address and data pair that is committed.

Top module: `serial_burst_regwriter`

## Requirements
- R1: A frame is sent MSB first. It holds one R/W flag bit (1 = write), then a 7-bit address, then whole data bytes. The bit is taken on each rising serial clock while chip-select is low.
- R2: The first data byte is committed after the 16th rising serial clock edge of a frame, and each further byte after every 8 more edges. Each commit raises `wr_stb` for exactly one system clock cycle, with `wr_addr` and `wr_data` valid in that cycle.
- R3: After every complete data byte the address pointer advances by one, whether the byte was stored or dropped. From 79 (4Fh) it goes to 0.
- R4: A complete byte aimed at address 14 (0Eh) or 49 (31h) gives no strobe and leaves that register unchanged.
- R5: A rising chip-select ends the frame at any bit. A partly received byte, or a partly received header, is discarded. The next frame starts again with a header.
- R6: A frame whose flag bit is 0 writes no register and raises no strobe.
- R7: While `pwr_dn_n` is low, every register reads 0, without waiting for a clock edge.
- R8: A header address from 80 to 127 drops the bytes aimed at it, and the byte after that goes to address 0.
- R9: `rd_data` shows the register at `rd_addr` combinationally. It reads 0 for `rd_addr` of 80 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data in |
| rd_addr | input | 7 | Read-back address |
| rd_data | output | 8 | Read-back register value |
| wr_stb | output | 1 | One-cycle pulse for each committed byte |
| wr_addr | output | 7 | Address of the committed byte |
| wr_data | output | 8 | Value of the committed byte |

## Verification
The hardest state to reach from the ports is a long burst in which the pointer wraps past 4Fh and crosses both protected addresses in one frame. The bench gets there with a 100-byte burst that starts at 40h, so the frame covers the wrap, both dropped addresses and an overwrite of bytes written earlier in the same frame. Frames cut off inside the header and inside a data byte are driven by ending chip-select after an arithmetic bit count. For each frame, the bench compares every strobe with a list computed in advance, including the serial edge count at which the strobe appears.

// File: rtl/serw_pkg.sv
package serw_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  // pointer step: anything at or past the last index wraps to zero
  function automatic addr_t next_addr(input addr_t a, input int last);
    return (int'(a) >= last) ? '0 : addr_t'(a + addr_t'(1));
  endfunction

  // write permission for an address
  function automatic logic addr_ok(input addr_t a, input int n, input int sa, input int sb);
    return (int'(a) < n) && (int'(a) != sa) && (int'(a) != sb);
  endfunction
endpackage

// File: rtl/serw_sync.sv
module serw_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/serw_frame.sv
module serw_frame
  import serw_pkg::*;
#(
  parameter int NUM_REGS = 80,
  parameter int SKIP_A   = 14,
  parameter int SKIP_B   = 49
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_s,
  input  logic  sclk_s,
  input  logic  sdat_s,
  output logic  wr_stb,
  output addr_t wr_addr,
  output byte_t wr_data
);
  localparam int LAST = NUM_REGS - 1;

  logic        sclk_d;
  logic [6:0]  sh_q;
  logic [2:0]  bit_idx;
  logic        hdr_done;
  logic        rw_q;
  addr_t       cur_addr;

  // named events
  wire sclk_rise = sclk_s & ~sclk_d;
  wire take_bit  = sclk_rise & ~cs_s;
  wire hdr_end   = take_bit & ~hdr_done & (bit_idx == 3'd7);
  wire byte_done = take_bit & hdr_done & (bit_idx == 3'd7);
  wire byte_keep = byte_done & rw_q & addr_ok(cur_addr, NUM_REGS, SKIP_A, SKIP_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      sh_q     <= '0;
      bit_idx  <= '0;
      hdr_done <= 1'b0;
      rw_q     <= 1'b0;
      cur_addr <= '0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      sclk_d <= sclk_s;
      wr_stb <= byte_keep;
      if (cs_s) begin
        bit_idx  <= '0;
        hdr_done <= 1'b0;
      end else if (take_bit) begin
        sh_q    <= {sh_q[5:0], sdat_s};
        bit_idx <= bit_idx + 3'd1;
        if (hdr_end) begin
          hdr_done <= 1'b1;
          rw_q     <= sh_q[6];
          cur_addr <= {sh_q[5:0], sdat_s};
        end
        if (byte_done) begin
          cur_addr <= next_addr(cur_addr, LAST);
          if (byte_keep) begin
            wr_addr <= cur_addr;
            wr_data <= {sh_q, sdat_s};
          end
        end
      end
    end
  end

  // R2
  stb_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R5
  no_stb_after_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !wr_stb);
  // R3
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (int'(cur_addr) < NUM_REGS));
  // R6
  read_frame_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !rw_q) |=> !wr_stb);
endmodule

// File: rtl/serw_regbank.sv
module serw_regbank
  import serw_pkg::*;
#(
  parameter int NUM_REGS = 80,
  parameter int SKIP_A   = 14,
  parameter int SKIP_B   = 49
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  addr_t waddr,
  input  byte_t wdata,
  input  addr_t raddr,
  output byte_t rdata
);
  byte_t regs [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign hit[g] = we && (int'(waddr) == g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (hit[i]) regs[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (int'(raddr) == i) rdata = regs[i];
  end

  // R4
  no_protected_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) != SKIP_A && int'(waddr) != SKIP_B));
  // R4
  protected_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs[SKIP_A]) && $stable(regs[SKIP_B]));
  // R8
  write_in_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < NUM_REGS));
endmodule

// File: rtl/serial_burst_regwriter.sv
module serial_burst_regwriter
  import serw_pkg::*;
#(
  parameter int NUM_REGS = 80,
  parameter int SKIP_A   = 14,
  parameter int SKIP_B   = 49
) (
  input  logic       clk,
  input  logic       pwr_dn_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       sdata,
  input  logic [6:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       wr_stb,
  output logic [6:0] wr_addr,
  output logic [7:0] wr_data
);
  logic [2:0] pins_s;

  serw_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (pwr_dn_n),
    .d_async ({cs_n, sclk, sdata}),
    .d_sync  (pins_s)
  );

  serw_frame #(.NUM_REGS(NUM_REGS), .SKIP_A(SKIP_A), .SKIP_B(SKIP_B)) u_frame (
    .clk     (clk),
    .rst_n   (pwr_dn_n),
    .cs_s    (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sdat_s  (pins_s[0]),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  serw_regbank #(.NUM_REGS(NUM_REGS), .SKIP_A(SKIP_A), .SKIP_B(SKIP_B)) u_bank (
    .clk   (clk),
    .rst_n (pwr_dn_n),
    .we    (wr_stb),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R7
  cleared_in_powerdown_chk: assert final (pwr_dn_n || rd_data == 8'h00);
endmodule

// File: tb/serial_burst_regwriter_tb_top.sv
module serial_burst_regwriter_tb_top;
  logic clk = 1'b0;
  logic pwr_dn_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic wr_stb;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  always #5 clk = ~clk;

  serial_burst_regwriter dut_i (
    .clk(clk), .pwr_dn_n(pwr_dn_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0, errs = 0;
  int rises = 0;
  logic [7:0] model [0:79];
  logic [7:0] dbuf  [0:127];
  int exp_a [0:127], exp_d [0:127], exp_e [0:127], exp_n;
  int obs_a [0:127], obs_d [0:127], obs_e [0:127], obs_n;

  function automatic bit may_write(int a);
    return (a < 80) && (a != 14) && (a != 49);
  endfunction
  function automatic int step(int a);
    return (a < 79) ? a + 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) if (wr_stb && obs_n < 128) begin
    obs_a[obs_n] = int'(wr_addr);
    obs_d[obs_n] = int'(wr_data);
    obs_e[obs_n] = rises;
    obs_n++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(int seed);
    for (int k = 0; k < 128; k++) dbuf[k] = 8'((k * 37 + seed * 11 + 5) % 256);
  endtask

  task automatic frame(string tag, bit rw, int a, int nbits);
    int nfull, ad;
    nfull = (nbits >= 16) ? (nbits - 8) / 8 : 0;
    exp_n = 0; ad = a;
    for (int k = 0; k < nfull; k++) begin
      if (rw && may_write(ad)) begin
        model[ad] = dbuf[k];
        exp_a[exp_n] = ad; exp_d[exp_n] = int'(dbuf[k]); exp_e[exp_n] = 16 + 8 * k;
        exp_n++;
      end
      ad = step(ad);
    end
    obs_n = 0; rises = 0;
    cs_n = 1'b0; tick(4);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      if (i == 0) sdata = rw;
      else if (i < 8) sdata = a[7 - i];
      else sdata = dbuf[(i - 8) / 8][7 - ((i - 8) % 8)];
      tick(4);
      sclk = 1'b1; rises++;
      tick(4);
    end
    sclk = 1'b0; tick(4);
    cs_n = 1'b1; tick(10);
    chk(tag, obs_n, exp_n, "strobe count");
    for (int j = 0; j < exp_n && j < obs_n; j++) begin
      chk(tag, obs_a[j], exp_a[j], "strobe addr");
      chk(tag, obs_d[j], exp_d[j], "strobe data");
      chk("R2", obs_e[j], exp_e[j], "strobe serial edge");
    end
  endtask

  task automatic bank(string tag);
    for (int a = 0; a < 128; a++) begin
      rd_addr = 7'(a); #1;
      chk(tag, int'(rd_data), (a < 80) ? int'(model[a]) : 0, "register read");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 80; a++) model[a] = 8'h00;
    tick(5); pwr_dn_n = 1'b1; tick(3);
    bank("R7_R9 reset");
    // R1 R2 R3 R4: long burst wrapping past 4Fh over both protected addresses
    fill(1); frame("R3_R4 burst", 1'b1, 64, 8 + 8 * 100); bank("R3_R4 burst");
    // R1: single-byte frames swept across the bank
    for (int s = 0; s < 80; s += 7) begin
      fill(s + 3); frame("R1 single", 1'b1, s, 16);
    end
    fill(9); frame("R4 direct", 1'b1, 14, 16); frame("R4 direct", 1'b1, 49, 16);
    bank("R1_R4 sweep");
    // R6: read-flag frame changes nothing
    fill(20); frame("R6 readflag", 1'b0, 5, 8 + 8 * 6); bank("R6 readflag");
    // R5: cut off in header, then in the third data byte
    fill(30); frame("R5 header cut", 1'b1, 2, 5);
    frame("R5 byte cut", 1'b1, 70, 8 + 16 + 5); bank("R5 cut");
    // R8: header address above the bank
    fill(40); frame("R8 high addr", 1'b1, 96, 8 + 24); bank("R8 high addr");
    frame("R8 top addr", 1'b1, 127, 8 + 16); bank("R8 top addr");
    // R7: asynchronous clear
    @(negedge clk); #2; pwr_dn_n = 1'b0; #1;
    for (int a = 0; a < 80; a++) model[a] = 8'h00;
    bank("R7 powerdown");
    tick(2); pwr_dn_n = 1'b1; tick(3);
    fill(50); frame("R7 after", 1'b1, 78, 8 + 24); bank("R7 after");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule